// File: doc/BRIEF.md
# Shared multiplexed memory bus controller

This block sits on the host side of a 16-bit address/data multiplexed bus that is shared by two memories: a flash device and a pseudo-SRAM. Each memory has its own chip, output and write enables. A host request carries a target select, a word address, write data, two byte enables and a flag that redirects a pseudo-SRAM access to its configuration registers. The controller runs one asynchronous access at a time. It opens an address phase with the latch enable low, then runs either a read phase of fixed length or a write phase of fixed length. It returns the read word along with a one-cycle completion pulse.

The controller never enables both memories at once. It keeps its own bus driver off whenever a memory may be driving. It holds the burst clock low because only asynchronous accesses are made. The pseudo-SRAM byte lanes follow the host byte enables, and the controller masks the disabled lanes out of the returned word. In a configuration access, address bits 19:18 pick the register. Writes aimed at the read-only identification register are dropped before any bus activity.

Top module: `mbus_ctrl`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle per request, and `req_ready` returns in the cycle after `done`.
- R2: `fl_ce_n` and `ps_ce_n` are never low together. During an access, the chip enable of the target that was not selected stays high.
- R3: The cycle that follows acceptance is the address phase. In it, `bus_adv_n` is low, `bus_ad_oe` is high, `bus_ad_o` carries address bits 15:0, `bus_hi` carries address bits 22:16, the selected chip enable is low, and both output and write enables are high.
- R4: A read holds the selected output enable low for RD_WAIT cycles after the address phase. The bus is sampled at the end of the last of these cycles, and `done` with `rdata` follows in the next cycle (RD_WAIT+2 cycles after acceptance, counting the accepting cycle as one).
- R5: A write holds the selected write enable low for WR_HOLD cycles after the address phase, with `bus_ad_oe` high and `bus_ad_o` equal to the write data. The output enable stays high, and `done` comes WR_HOLD+2 cycles after acceptance.
- R6: `bus_ad_oe` is low while idle, while either output enable is low, and in the completion cycle.
- R7: `bus_clk` is low at all times.
- R8: During a pseudo-SRAM access, `ps_ub_n` is the inverse of `req_be[1]` (bits 15:8) and `ps_lb_n` is the inverse of `req_be[0]` (bits 7:0). Both stay high during flash accesses and while idle.
- R9: In a pseudo-SRAM read, a disabled byte lane returns zero in `rdata`. With both byte enables low, the chip enable is still held for the whole access, and `rdata` is zero.
- R10: `req_cfg` on a pseudo-SRAM request raises `ps_cre` for the whole bus access, and `bus_hi[3:2]` (address bits 19:18) selects the register: 00 refresh settings, 10 bus settings, x1 read-only identification.
- R11: A configuration write with address bit 18 set makes no bus access: no chip enable, write enable or latch enable goes low, and `done` comes in the cycle after acceptance.
- R12: For pseudo-SRAM accesses, `bus_hi[6]` (address bit 22, used by the flash only) is driven zero. Flash accesses ignore `req_cfg` and `req_be`, and return the full word.
- R13: During and after reset, all enables and the latch enable are high, `bus_ad_oe` is low, `done` is low, `rdata` is zero and `req_ready` is high. An access cut by reset leaves no enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_target | input | 1 | 0 flash, 1 pseudo-SRAM |
| req_write | input | 1 | 1 write, 0 read |
| req_cfg | input | 1 | Pseudo-SRAM configuration register access |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, valid with done |
| bus_ad_o | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Host driver enable for the shared pins |
| bus_ad_i | input | 16 | Multiplexed data in |
| bus_hi | output | 7 | Upper address pins |
| bus_adv_n | output | 1 | Address latch enable, low in address phase |
| bus_clk | output | 1 | Burst clock, held low |
| fl_ce_n | output | 1 | Flash chip enable |
| fl_oe_n | output | 1 | Flash output enable |
| fl_we_n | output | 1 | Flash write enable |
| ps_ce_n | output | 1 | Pseudo-SRAM chip enable |
| ps_oe_n | output | 1 | Pseudo-SRAM output enable |
| ps_we_n | output | 1 | Pseudo-SRAM write enable |
| ps_ub_n | output | 1 | Pseudo-SRAM upper byte enable |
| ps_lb_n | output | 1 | Pseudo-SRAM lower byte enable |
| ps_cre | output | 1 | Pseudo-SRAM configuration register select |

## Verification
Counting the accepting cycle as one, the address phase is due in cycle one. A read's `done` and `rdata` are due in cycle RD_WAIT+2, a write's `done` in cycle WR_HOLD+2, and a dropped identification write's `done` in cycle one. `req_ready` returns in the cycle after `done`. The bench drives inputs and samples outputs on falling edges. It numbers the cycles from acceptance and checks the address phase on cycle one and the enable counts across the access. It compares the arrival cycle of `done` with the expected latency from each vector.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_RWAIT = 3'd2,
        ST_WHOLD = 3'd3,
        ST_END   = 3'd4
    } mbus_state_e;

    typedef enum logic [1:0] {
        CREG_REFRESH = 2'd0,
        CREG_BUSCFG  = 2'd1,
        CREG_DEVID   = 2'd2
    } creg_e;

    localparam int NUM_TGT   = 2;
    localparam int TGT_FLASH = 0;
    localparam int TGT_PSRAM = 1;

endpackage

// File: rtl/mbus_creg_decode.sv
module mbus_creg_decode
    import mbus_pkg::*;
(
    input  logic [1:0] sel_bits,
    input  logic       cfg,
    input  logic       to_psram,
    input  logic       write,
    output logic       cre,
    output logic       wr_block
);
    creg_e sel;

    always_comb begin
        if (sel_bits[0])      sel = CREG_DEVID;
        else if (sel_bits[1]) sel = CREG_BUSCFG;
        else                  sel = CREG_REFRESH;
    end

    assign cre      = cfg & to_psram;
    assign wr_block = cre & write & (sel == CREG_DEVID);

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      sel_drive,
    input  logic                      mask_en,
    input  logic [LANES-1:0]          be,
    input  logic [LANES*LANE_W-1:0]   raw,
    output logic [LANES-1:0]          lane_n,
    output logic [LANES*LANE_W-1:0]   masked
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ~(sel_drive & be[i]);
        assign masked[i*LANE_W +: LANE_W] =
            (!mask_en || be[i]) ? raw[i*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
    import mbus_pkg::*;
#(
    parameter int TGTS  = NUM_TGT,
    localparam int TGT_W = (TGTS > 1) ? $clog2(TGTS) : 1
) (
    input  mbus_state_e       state,
    input  logic [TGT_W-1:0]  tgt,
    output logic [TGTS-1:0]   ce_n,
    output logic [TGTS-1:0]   oe_n,
    output logic [TGTS-1:0]   we_n,
    output logic              adv_n,
    output logic              ad_drive,
    output logic              busy
);
    assign busy     = (state == ST_ADDR) || (state == ST_RWAIT) || (state == ST_WHOLD);
    assign adv_n    = (state != ST_ADDR);
    assign ad_drive = (state == ST_ADDR) || (state == ST_WHOLD);

    for (genvar t = 0; t < TGTS; t++) begin : g_tgt
        logic hit;
        assign hit     = (tgt == TGT_W'(t));
        assign ce_n[t] = ~(busy & hit);
        assign oe_n[t] = ~((state == ST_RWAIT) & hit);
        assign we_n[t] = ~((state == ST_WHOLD) & hit);
    end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W       = 23,
    parameter int DATA_W       = 16,
    parameter int PS_ADDR_W    = 22,
    parameter int RD_WAIT      = 3,
    parameter int WR_HOLD      = 2,
    parameter int CREG_SEL_LSB = 18,
    localparam int HI_W        = ADDR_W - DATA_W,
    localparam int LANES       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_target,
    input  logic              req_write,
    input  logic              req_cfg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [HI_W-1:0]   bus_hi,
    output logic              bus_adv_n,
    output logic              bus_clk,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              ps_ce_n,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic              ps_ub_n,
    output logic              ps_lb_n,
    output logic              ps_cre
);
    localparam int CNT_MAX = (RD_WAIT > WR_HOLD) ? RD_WAIT : WR_HOLD;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX + 1) : 1;
    localparam logic [ADDR_W-1:0] PS_MASK =
        {{(ADDR_W - PS_ADDR_W){1'b0}}, {PS_ADDR_W{1'b1}}};

    typedef struct packed {
        mbus_state_e        st;
        logic               tgt;
        logic               wr;
        logic               cre;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   be;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic dec_cre, dec_block;
    logic [NUM_TGT-1:0] ce_n_v, oe_n_v, we_n_v;
    logic adv_n_w, drive_w, busy_w;
    logic [LANES-1:0]  lane_n;
    logic [DATA_W-1:0] rd_masked;

    mbus_creg_decode u_creg (
        .sel_bits (req_addr[CREG_SEL_LSB +: 2]),
        .cfg      (req_cfg),
        .to_psram (req_target),
        .write    (req_write),
        .cre      (dec_cre),
        .wr_block (dec_block)
    );

    mbus_strobe #(.TGTS(NUM_TGT)) u_strobe (
        .state    (ctl_q.st),
        .tgt      (ctl_q.tgt),
        .ce_n     (ce_n_v),
        .oe_n     (oe_n_v),
        .we_n     (we_n_v),
        .adv_n    (adv_n_w),
        .ad_drive (drive_w),
        .busy     (busy_w)
    );

    mbus_lane #(.LANE_W(8), .LANES(LANES)) u_lane (
        .sel_drive (busy_w & ctl_q.tgt),
        .mask_en   (ctl_q.tgt),
        .be        (ctl_q.be),
        .raw       (bus_ad_i),
        .lane_n    (lane_n),
        .masked    (rd_masked)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.tgt   = req_target;
                    ctl_d.wr    = req_write;
                    ctl_d.cre   = dec_cre;
                    ctl_d.addr  = req_target ? (req_addr & PS_MASK) : req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.be    = req_be;
                    ctl_d.rdata = '0;
                    ctl_d.cnt   = '0;
                    ctl_d.st    = dec_block ? ST_END : ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (ctl_q.wr) begin
                    ctl_d.st  = ST_WHOLD;
                    ctl_d.cnt = CNT_W'(WR_HOLD - 1);
                end else begin
                    ctl_d.st  = ST_RWAIT;
                    ctl_d.cnt = CNT_W'(RD_WAIT - 1);
                end
            end
            ST_RWAIT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.rdata = rd_masked;
                    ctl_d.st    = ST_END;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_END;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_END: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.cre = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign done      = (ctl_q.st == ST_END);
    assign rdata     = ctl_q.rdata;

    assign bus_ad_oe = drive_w;
    assign bus_ad_o  = (ctl_q.st == ST_ADDR)  ? ctl_q.addr[DATA_W-1:0] :
                       (ctl_q.st == ST_WHOLD) ? ctl_q.wdata : '0;
    assign bus_hi    = busy_w ? ctl_q.addr[ADDR_W-1:DATA_W] : '0;
    assign bus_adv_n = adv_n_w;
    assign bus_clk   = 1'b0;

    assign fl_ce_n = ce_n_v[TGT_FLASH];
    assign fl_oe_n = oe_n_v[TGT_FLASH];
    assign fl_we_n = we_n_v[TGT_FLASH];
    assign ps_ce_n = ce_n_v[TGT_PSRAM];
    assign ps_oe_n = oe_n_v[TGT_PSRAM];
    assign ps_we_n = we_n_v[TGT_PSRAM];
    assign ps_ub_n = lane_n[LANES-1];
    assign ps_lb_n = lane_n[0];
    assign ps_cre  = busy_w & ctl_q.cre;

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic bus_ad_oe,
    input logic bus_adv_n,
    input logic fl_ce_n,
    input logic fl_oe_n,
    input logic fl_we_n,
    input logic ps_ce_n,
    input logic ps_oe_n,
    input logic ps_we_n,
    input logic ps_ub_n,
    input logic ps_lb_n,
    input logic ps_cre
);
    AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_ce_n && !ps_ce_n)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && ps_ce_n && bus_adv_n && !bus_ad_oe)); // R13
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n || !ps_oe_n) |-> !bus_ad_oe); // R6
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !ps_we_n) |-> (bus_ad_oe && fl_oe_n && ps_oe_n)); // R5
    AST_LATCH_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_adv_n |-> (!fl_ce_n || !ps_ce_n)); // R3
    AST_CRE_PSRAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ps_cre |-> (!ps_ce_n && fl_ce_n)); // R10
    AST_FLASH_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ps_ce_n |-> (ps_ub_n && ps_lb_n)); // R8
endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .bus_ad_oe (bus_ad_oe),
    .bus_adv_n (bus_adv_n),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .ps_ce_n   (ps_ce_n),
    .ps_oe_n   (ps_oe_n),
    .ps_we_n   (ps_we_n),
    .ps_ub_n   (ps_ub_n),
    .ps_lb_n   (ps_lb_n),
    .ps_cre    (ps_cre)
);

// File: tb/mbus_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_ctrl_tb_top;
    localparam int RDW = 3;
    localparam int WRH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_target = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic req_ready, done, bus_ad_oe, bus_adv_n, bus_clk;
    logic [15:0] rdata, bus_ad_o, bus_ad_i;
    logic [6:0]  bus_hi;
    logic fl_ce_n, fl_oe_n, fl_we_n, ps_ce_n, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n, ps_cre;
    logic [15:0] cur_rd = 16'h0;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    assign bus_ad_i = (!fl_oe_n || !ps_oe_n) ? cur_rd : 16'hDEAD;

    mbus_ctrl #(.RD_WAIT(RDW), .WR_HOLD(WRH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_write(req_write), .req_cfg(req_cfg),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .done(done), .rdata(rdata), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i), .bus_hi(bus_hi), .bus_adv_n(bus_adv_n), .bus_clk(bus_clk),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .ps_ce_n(ps_ce_n), .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n),
        .ps_ub_n(ps_ub_n), .ps_lb_n(ps_lb_n), .ps_cre(ps_cre)
    );

    typedef struct packed {
        logic        tgt;
        logic        cfg;
        logic        wr;
        logic [22:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
        logic [15:0] rd;
        logic [15:0] exp_rd;
        logic [6:0]  exp_hi;
        logic [1:0]  exp_lanes;
        logic        exp_cre;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 23'h5A1234, 16'h0000, 2'b00, 16'hBEEF, 16'hBEEF, 7'h5A, 2'b00, 1'b0, 4'd5},
        '{1'b0, 1'b0, 1'b1, 23'h7F0002, 16'h1357, 2'b00, 16'h0000, 16'h0000, 7'h7F, 2'b00, 1'b0, 4'd4},
        '{1'b1, 1'b0, 1'b0, 23'h7F00AA, 16'h0000, 2'b11, 16'hCAFE, 16'hCAFE, 7'h3F, 2'b11, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b0, 23'h010010, 16'h0000, 2'b01, 16'hA5C3, 16'h00C3, 7'h01, 2'b01, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b0, 23'h010020, 16'h0000, 2'b10, 16'hA5C3, 16'hA500, 7'h01, 2'b10, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b0, 23'h020030, 16'h0000, 2'b00, 16'hFFFF, 16'h0000, 7'h02, 2'b00, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b1, 23'h123456, 16'h9ABC, 2'b10, 16'h0000, 16'h0000, 7'h12, 2'b10, 1'b0, 4'd4},
        '{1'b1, 1'b1, 1'b1, 23'h030010, 16'h0011, 2'b11, 16'h0000, 16'h0000, 7'h03, 2'b11, 1'b1, 4'd4},
        '{1'b1, 1'b1, 1'b1, 23'h080000, 16'h0022, 2'b11, 16'h0000, 16'h0000, 7'h08, 2'b11, 1'b1, 4'd4},
        '{1'b1, 1'b1, 1'b1, 23'h040000, 16'h0033, 2'b11, 16'h0000, 16'h0000, 7'h00, 2'b00, 1'b0, 4'd1},
        '{1'b1, 1'b1, 1'b0, 23'h040000, 16'h0000, 2'b11, 16'h0123, 16'h0123, 7'h04, 2'b11, 1'b1, 4'd5},
        '{1'b1, 1'b1, 1'b1, 23'h0C0000, 16'h0044, 2'b11, 16'h0000, 16'h0000, 7'h00, 2'b00, 1'b0, 4'd1},
        '{1'b0, 1'b1, 1'b0, 23'h440000, 16'h0000, 2'b01, 16'h7788, 16'h7788, 7'h44, 2'b00, 1'b0, 4'd5}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic check_idle(input string tag);
        chk("R13", {tag, " ready"}, req_ready, 1);
        chk("R13", {tag, " done"}, done, 0);
        chk("R13", {tag, " enables"}, {fl_ce_n, fl_oe_n, fl_we_n, ps_ce_n, ps_oe_n, ps_we_n}, 6'h3F);
        chk("R13", {tag, " latch"}, bus_adv_n, 1);
        chk("R6", {tag, " driver"}, bus_ad_oe, 0);
        chk("R8", {tag, " lanes"}, {ps_ub_n, ps_lb_n}, 2'b11);
        chk("R7", {tag, " clock"}, bus_clk, 0);
    endtask

    task automatic run_vec(input vec_t v);
        int idx, oe_cyc, we_cyc;
        logic fl_seen, ps_seen, seen_done;
        string rrq;
        rrq = (v.tgt && v.be != 2'b11) ? "R9" : "R4";
        cur_rd = v.rd;
        req_target = v.tgt; req_write = v.wr; req_cfg = v.cfg;
        req_addr = v.addr; req_wdata = v.wdata; req_be = v.be; req_valid = 1'b1;
        chk("R1", "ready before issue", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        idx = 1; oe_cyc = 0; we_cyc = 0; fl_seen = 0; ps_seen = 0; seen_done = 0;
        for (int k = 0; k < 30; k++) begin
            if (done) begin seen_done = 1; break; end
            chk("R2", "ce exclusive", {fl_ce_n, ps_ce_n} != 2'b00, 1);
            chk("R7", "burst clock", bus_clk, 0);
            chk("R1", "ready low in access", req_ready, 0);
            if (!fl_ce_n) fl_seen = 1;
            if (!ps_ce_n) ps_seen = 1;
            if (idx == 1) begin
                chk("R3", "latch low", bus_adv_n, 0);
                chk("R3", "addr drive", bus_ad_oe, 1);
                chk("R3", "addr low bits", bus_ad_o, v.addr[15:0]);
                chk("R3", "oe/we high", {fl_oe_n, fl_we_n, ps_oe_n, ps_we_n}, 4'hF);
                chk("R12", "upper pins", bus_hi, v.exp_hi);
                chk("R10", "cre", ps_cre, v.exp_cre);
                chk("R8", "lanes addr", {~ps_ub_n, ~ps_lb_n}, v.exp_lanes);
            end else begin
                chk("R3", "latch high after", bus_adv_n, 1);
            end
            if (!fl_oe_n || !ps_oe_n) begin
                oe_cyc++;
                chk("R6", "no drive on read", bus_ad_oe, 0);
                chk("R8", "lanes read", {~ps_ub_n, ~ps_lb_n}, v.exp_lanes);
                chk("R10", "cre read", ps_cre, v.exp_cre);
            end
            if (!fl_we_n || !ps_we_n) begin
                we_cyc++;
                chk("R5", "write drive", bus_ad_oe, 1);
                chk("R5", "write data", bus_ad_o, v.wdata);
                chk("R8", "lanes write", {~ps_ub_n, ~ps_lb_n}, v.exp_lanes);
                chk("R12", "upper pins write", bus_hi, v.exp_hi);
            end
            idx++;
            @(negedge clk);
        end
        chk("R1", "done seen", seen_done, 1);
        if (v.lat == 4'd1) begin
            chk("R11", "blocked latency", idx, 1);
            chk("R11", "blocked no ce", {fl_seen, ps_seen}, 2'b00);
        end else begin
            chk(v.wr ? "R5" : "R4", "latency", idx, v.lat);
            chk("R2", "target ce", {fl_seen, ps_seen}, {~v.tgt, v.tgt});
            chk(v.wr ? "R5" : "R4", "oe cycles", oe_cyc, v.wr ? 0 : RDW);
            chk(v.wr ? "R5" : "R4", "we cycles", we_cyc, v.wr ? WRH : 0);
            if (!v.wr) chk(v.tgt ? rrq : "R12", "rdata", rdata, v.exp_rd);
        end
        chk("R6", "driver off at done", bus_ad_oe, 0);
        @(negedge clk);
        chk("R1", "done single", done, 0);
        chk("R1", "ready back", req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        @(negedge clk);
        check_idle("in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");
        chk("R13", "rdata reset", rdata, 16'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: nothing starts without req_valid
        repeat (4) begin
            @(negedge clk);
            chk("R1", "no request ce", {fl_ce_n, ps_ce_n}, 2'b11);
            chk("R1", "no request done", done, 0);
        end

        // R13: reset in the middle of a pseudo-SRAM write
        req_target = 1'b1; req_write = 1'b1; req_cfg = 1'b0;
        req_addr = 23'h001234; req_wdata = 16'h5555; req_be = 2'b11; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R5", "mid write we", ps_we_n, 0);
        rst_n = 1'b0;
        #1;
        check_idle("reset mid access");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after mid reset");

        // R11: blocked write right after reset, then a normal read
        run_vec(VECS[9]);
        run_vec(VECS[3]);

        finish_run();
    end
endmodule